// File: doc/BRIEF.md
# Serial Offset Register Loader

This block fills the four watermark offsets of a two-FIFO device: two almost-empty offsets (Y1, Y2) and two almost-full offsets (X1, X2). Software or a board strap decides how they are filled when master reset is released. In serial mode the four values arrive as one 56-bit stream on a single data pin. One bit is taken on each port A clock edge while an active-low enable is held low. In parallel mode each port A write strobe delivers one whole offset from the data bus. In that mode an interspersed-parity option can be selected, which makes bus bit 8 a parity position that is skipped. Choosing interspersed parity rules out serial loading.

Each port has a ready flag that stays low while the offsets are incomplete. The port A flag rises one port A clock after the last bit or word. The port B flag follows through a two-stage synchronizer clocked by the port B clock. Keeping each offset within 1 to 16,380 is the caller's responsibility. The block stores whatever arrives.

Top module: `offset_serial_loader`

## Requirements
- R1: While `rst_a` is sampled high, the next `clk_a` edge leaves all four offsets at zero and `rdy_a` low. While `rst_b` is sampled high, `rdy_b` is low after the next `clk_b` edge.
- R2: Serial mode is chosen only when, in the last cycle with `rst_a` high, `mode_fs2`=0, `ser_data`=0, `ser_en_n`=1 and `parity_sel`=0. Any other combination chooses parallel mode.
- R3: In serial mode, each `clk_a` edge with `ser_en_n`=0 appends `ser_data` to a stream taken MSB first in the order Y1, X1, Y2, X2. The first bit is Y1[13] and the 56th bit is X2[0]. An edge with `ser_en_n`=1 changes nothing.
- R4: Once 56 bits are taken, further serial enable cycles leave all offsets unchanged.
- R5: `rdy_a` stays low until the load is complete. It rises on the `clk_a` edge after the edge that takes the last bit (or fourth word), and it stays high until the next master reset.
- R6: `rdy_b` is `rdy_a` passed through two `clk_b` flops. It rises on the second `clk_b` edge at which `rdy_a` is seen high.
- R7: With `parity_sel`=1 at reset, serial loading is disabled: `ser_en_n` and `ser_data` have no effect on the offsets.
- R8: In parallel mode without parity, each `clk_a` edge with `par_wr`=1 stores `par_bus[13:0]` into the next offset in the order Y1, X1, Y2, X2.
- R9: In parallel mode with parity, `par_bus[8]` is ignored and the stored value is {`par_bus[14:9]`, `par_bus[7:0]`}.
- R10: Parallel writes after the fourth leave all offsets unchanged.
- R11: A master reset in the middle of a load clears the offsets and the progress. Loading restarts from Y1[13] (or word Y1) in the newly selected mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a | input | 1 | Master reset, synchronous to `clk_a`, active high |
| clk_b | input | 1 | Port B clock |
| rst_b | input | 1 | Port B reset, synchronous to `clk_b`, active high |
| mode_fs2 | input | 1 | Mode strap sampled during reset |
| ser_data | input | 1 | Serial data; also a mode strap during reset |
| ser_en_n | input | 1 | Serial enable, active low; also a mode strap during reset |
| parity_sel | input | 1 | Interspersed-parity select, sampled during reset |
| par_wr | input | 1 | Parallel offset write strobe |
| par_bus | input | 36 | Parallel offset data bus |
| ofs_y1 | output | 14 | First almost-empty offset |
| ofs_x1 | output | 14 | First almost-full offset |
| ofs_y2 | output | 14 | Second almost-empty offset |
| ofs_x2 | output | 14 | Second almost-full offset |
| rdy_a | output | 1 | Port A ready flag |
| rdy_b | output | 1 | Port B ready flag |

## Verification
The hardest state to reach from the ports is a reset that arrives part-way through a serial stream. Reaching it means first selecting serial mode through straps that share pins with the data and enable, then stopping after a partial bit count. The stimulus shifts 20 bits, re-enters reset with the same straps, and then streams a full second pattern. The per-clock model must show all offsets cleared and the count restarted. Enable gaps with toggling data, and enable pulses sent after the 56th bit, cover the cases where the serial enable must be ignored. Running the port B clock at a different rate and phase makes the synchronizer latency observable.

// File: rtl/offs_pkg.sv
package offs_pkg;
  // Load configuration captured while master reset is held
  typedef struct packed {
    logic serial_sel;   // stream offsets through the one-bit input
    logic parity_sel;   // parallel words carry a parity bit inside the value field
  } load_cfg_t;
endpackage

// File: rtl/offs_mode_latch.sv
module offs_mode_latch
  import offs_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      fs2_i,
  input  logic      sd_i,
  input  logic      sen_n_i,
  input  logic      parity_i,
  output load_cfg_t cfg_o
);
  // Straps are resampled every reset cycle; the last one before release wins
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_o.serial_sel <= ~fs2_i & ~sd_i & sen_n_i & ~parity_i;
      cfg_o.parity_sel <= parity_i;
    end
  end
endmodule

// File: rtl/offs_load_seq.sv
module offs_load_seq
  import offs_pkg::*;
#(
  parameter int TOTAL_BITS = 56,
  parameter int NUM_REGS   = 4,
  parameter int CNT_W      = 6,
  parameter int IDX_W      = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  load_cfg_t        cfg_i,
  input  logic             sen_n_i,
  input  logic             par_wr_i,
  output logic             shift_en_o,
  output logic             word_we_o,
  output logic [IDX_W-1:0] word_idx_o,
  output logic             rdy_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;
  logic             done;

  // Progress counts bits in serial mode and words in parallel mode
  assign limit      = cfg_i.serial_sel ? CNT_W'(TOTAL_BITS) : CNT_W'(NUM_REGS);
  assign done       = (cnt_q == limit);
  assign shift_en_o = ~rst & cfg_i.serial_sel & ~sen_n_i & ~done;
  assign word_we_o  = ~rst & ~cfg_i.serial_sel & par_wr_i & ~done;
  assign word_idx_o = cnt_q[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (shift_en_o || word_we_o) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // Ready follows completion by one port A edge
  always_ff @(posedge clk) begin
    if (rst) rdy_o <= 1'b0;
    else     rdy_o <= done;
  end
endmodule

// File: rtl/offs_regfile.sv
module offs_regfile #(
  parameter int OFS_W    = 14,
  parameter int NUM_REGS = 4,
  parameter int BUS_W    = 36,
  parameter int PAR_BIT  = 8,
  parameter int IDX_W    = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      parity_i,
  input  logic                      shift_en_i,
  input  logic                      ser_bit_i,
  input  logic                      word_we_i,
  input  logic [IDX_W-1:0]          word_idx_i,
  input  logic [BUS_W-1:0]          bus_i,
  output logic [OFS_W*NUM_REGS-1:0] vec_o
);
  localparam int TOTAL = OFS_W * NUM_REGS;

  logic [OFS_W-1:0] word_val;

  // With parity on, the value field skips the parity position
  always_comb begin
    word_val = '0;
    for (int i = 0; i < OFS_W; i++) begin
      if (parity_i && i >= PAR_BIT) word_val[i] = bus_i[i+1];
      else                          word_val[i] = bus_i[i];
    end
  end

  // Slot 0 occupies the top bits so a left shift streams it MSB first
  always_ff @(posedge clk) begin
    if (rst) begin
      vec_o <= '0;
    end else if (shift_en_i) begin
      vec_o <= {vec_o[TOTAL-2:0], ser_bit_i};
    end else if (word_we_i) begin
      for (int k = 0; k < NUM_REGS; k++) begin
        if (word_idx_i == IDX_W'(k)) vec_o[TOTAL-1-k*OFS_W -: OFS_W] <= word_val;
      end
    end
  end
endmodule

// File: rtl/offs_rdy_sync.sv
module offs_rdy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/offset_serial_loader.sv
module offset_serial_loader
  import offs_pkg::*;
#(
  parameter int OFS_W       = 14,
  parameter int BUS_W       = 36,
  parameter int PAR_BIT     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_a,
  input  logic             rst_a,
  input  logic             clk_b,
  input  logic             rst_b,
  input  logic             mode_fs2,
  input  logic             ser_data,
  input  logic             ser_en_n,
  input  logic             parity_sel,
  input  logic             par_wr,
  input  logic [BUS_W-1:0] par_bus,
  output logic [OFS_W-1:0] ofs_y1,
  output logic [OFS_W-1:0] ofs_x1,
  output logic [OFS_W-1:0] ofs_y2,
  output logic [OFS_W-1:0] ofs_x2,
  output logic             rdy_a,
  output logic             rdy_b
);
  // Four named offsets are fixed by the port list
  localparam int NUM_REGS   = 4;
  localparam int TOTAL_BITS = OFS_W * NUM_REGS;
  localparam int CNT_W      = $clog2(TOTAL_BITS + 1);
  localparam int IDX_W      = $clog2(NUM_REGS);

  load_cfg_t            cfg_q;
  logic                 shift_en;
  logic                 word_we;
  logic [IDX_W-1:0]     word_idx;
  logic [TOTAL_BITS-1:0] ofs_vec;

  offs_mode_latch u_mode (
    .clk      (clk_a),
    .rst      (rst_a),
    .fs2_i    (mode_fs2),
    .sd_i     (ser_data),
    .sen_n_i  (ser_en_n),
    .parity_i (parity_sel),
    .cfg_o    (cfg_q)
  );

  offs_load_seq #(
    .TOTAL_BITS (TOTAL_BITS),
    .NUM_REGS   (NUM_REGS),
    .CNT_W      (CNT_W),
    .IDX_W      (IDX_W)
  ) u_seq (
    .clk        (clk_a),
    .rst        (rst_a),
    .cfg_i      (cfg_q),
    .sen_n_i    (ser_en_n),
    .par_wr_i   (par_wr),
    .shift_en_o (shift_en),
    .word_we_o  (word_we),
    .word_idx_o (word_idx),
    .rdy_o      (rdy_a)
  );

  offs_regfile #(
    .OFS_W    (OFS_W),
    .NUM_REGS (NUM_REGS),
    .BUS_W    (BUS_W),
    .PAR_BIT  (PAR_BIT),
    .IDX_W    (IDX_W)
  ) u_regs (
    .clk        (clk_a),
    .rst        (rst_a),
    .parity_i   (cfg_q.parity_sel),
    .shift_en_i (shift_en),
    .ser_bit_i  (ser_data),
    .word_we_i  (word_we),
    .word_idx_i (word_idx),
    .bus_i      (par_bus),
    .vec_o      (ofs_vec)
  );

  offs_rdy_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync_b (
    .clk (clk_b),
    .rst (rst_b),
    .d_i (rdy_a),
    .q_o (rdy_b)
  );

  assign ofs_y1 = ofs_vec[TOTAL_BITS-1          -: OFS_W];
  assign ofs_x1 = ofs_vec[TOTAL_BITS-1-OFS_W    -: OFS_W];
  assign ofs_y2 = ofs_vec[TOTAL_BITS-1-2*OFS_W  -: OFS_W];
  assign ofs_x2 = ofs_vec[TOTAL_BITS-1-3*OFS_W  -: OFS_W];
endmodule

// File: rtl/offs_loader_checker.sv
module offs_loader_checker #(
  parameter int OFS_W = 14
) (
  input logic             clk_a,
  input logic             rst_a,
  input logic             clk_b,
  input logic             rst_b,
  input logic             ser_en_n,
  input logic             par_wr,
  input logic             ser_mode,
  input logic             par_mode,
  input logic [OFS_W-1:0] ofs_y1,
  input logic [OFS_W-1:0] ofs_x1,
  input logic [OFS_W-1:0] ofs_y2,
  input logic [OFS_W-1:0] ofs_x2,
  input logic             rdy_a,
  input logic             rdy_b
);
  logic [4*OFS_W-1:0] all_ofs;
  assign all_ofs = {ofs_y1, ofs_x1, ofs_y2, ofs_x2};

  a_r1_reset_clears: assert property (@(posedge clk_a)
    rst_a |=> (!rdy_a && all_ofs == '0));

  a_r5_ready_holds: assert property (@(posedge clk_a) disable iff (rst_a)
    rdy_a |=> rdy_a);

  a_r4_frozen_when_ready: assert property (@(posedge clk_a) disable iff (rst_a)
    rdy_a |=> $stable(all_ofs));

  a_r3_idle_enable_holds: assert property (@(posedge clk_a) disable iff (rst_a)
    (ser_mode && ser_en_n) |=> $stable(all_ofs));

  a_r7_parity_blocks_serial: assert property (@(posedge clk_a) disable iff (rst_a)
    (par_mode && !par_wr) |=> $stable(all_ofs));

  a_r6_rise_follows_source: assert property (@(posedge clk_b) disable iff (rst_b)
    $rose(rdy_b) |-> $past(rdy_a, 2));
endmodule

bind offset_serial_loader offs_loader_checker #(.OFS_W(OFS_W)) u_chk (
  .clk_a    (clk_a),
  .rst_a    (rst_a),
  .clk_b    (clk_b),
  .rst_b    (rst_b),
  .ser_en_n (ser_en_n),
  .par_wr   (par_wr),
  .ser_mode (cfg_q.serial_sel),
  .par_mode (cfg_q.parity_sel),
  .ofs_y1   (ofs_y1),
  .ofs_x1   (ofs_x1),
  .ofs_y2   (ofs_y2),
  .ofs_x2   (ofs_x2),
  .rdy_a    (rdy_a),
  .rdy_b    (rdy_b)
);

// File: tb/tb_offset_serial_loader.sv
module tb_offset_serial_loader;
  localparam int W     = 14;
  localparam int BUS_W = 36;
  localparam int TOT   = 4 * W;

  logic clk_a = 1'b0;
  logic clk_b = 1'b0;
  logic rst_a = 1'b1;
  logic rst_b = 1'b1;
  logic mode_fs2 = 1'b0, ser_data = 1'b0, ser_en_n = 1'b1, parity_sel = 1'b0, par_wr = 1'b0;
  logic [BUS_W-1:0] par_bus = '0;
  logic [W-1:0] ofs_y1, ofs_x1, ofs_y2, ofs_x2;
  logic rdy_a, rdy_b;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  bit finished = 0;
  bit started = 0;
  string phase_tag = "R1";

  always #5 clk_a = ~clk_a;
  initial begin
    #2;
    forever #10 clk_b = ~clk_b;
  end

  offset_serial_loader dut (
    .clk_a(clk_a), .rst_a(rst_a), .clk_b(clk_b), .rst_b(rst_b),
    .mode_fs2(mode_fs2), .ser_data(ser_data), .ser_en_n(ser_en_n),
    .parity_sel(parity_sel), .par_wr(par_wr), .par_bus(par_bus),
    .ofs_y1(ofs_y1), .ofs_x1(ofs_x1), .ofs_y2(ofs_y2), .ofs_x2(ofs_x2),
    .rdy_a(rdy_a), .rdy_b(rdy_b)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Behavioural reference model
  bit m_ser = 0, m_par = 0, m_rdya = 0, m_b1 = 0, m_b2 = 0;
  int m_cnt = 0;
  logic [TOT-1:0] m_vec = '0;

  always @(posedge clk_a) begin
    started = 1;
    if (rst_a) begin
      m_ser = !mode_fs2 && !ser_data && ser_en_n && !parity_sel;
      m_par = parity_sel;
      m_cnt = 0; m_vec = '0; m_rdya = 0;
    end else begin
      int lim;
      logic [W-1:0] val;
      lim = m_ser ? TOT : 4;
      m_rdya = (m_cnt == lim);
      if (m_ser) begin
        if (!ser_en_n && m_cnt < TOT) begin
          m_vec = {m_vec[TOT-2:0], ser_data};
          m_cnt++;
        end
      end else if (par_wr && m_cnt < 4) begin
        val = m_par ? {par_bus[14:9], par_bus[7:0]} : par_bus[13:0];
        m_vec[TOT-1-W*m_cnt -: W] = val;
        m_cnt++;
      end
    end
  end

  always @(posedge clk_b) begin
    if (rst_b) begin m_b1 = 0; m_b2 = 0; end
    else begin m_b2 = m_b1; m_b1 = m_rdya; end
  end

  always @(negedge clk_a) begin
    if (started && !finished) begin
      chk(phase_tag, "offsets", {ofs_y1, ofs_x1, ofs_y2, ofs_x2}, m_vec);
      chk("R5", "rdy_a", rdy_a, m_rdya);
    end
  end

  always @(negedge clk_b) begin
    if (started && !finished) chk("R6", "rdy_b", rdy_b, m_b2);
  end

  // Watchdog
  always @(posedge clk_a) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=%0d expected=<20000 cycles", cyc);
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_a);
  endtask

  task automatic do_reset(input logic fs2, input logic sd, input logic sen, input logic par);
    @(negedge clk_a);
    rst_a = 1; rst_b = 1; par_wr = 0;
    mode_fs2 = fs2; ser_data = sd; ser_en_n = sen; parity_sel = par;
    step(3);
    rst_a = 0; rst_b = 0; ser_en_n = 1; ser_data = 0;
  endtask

  task automatic send_bits(input logic [TOT-1:0] v, input int nbits);
    for (int i = TOT - 1; i >= TOT - nbits; i--) begin
      @(negedge clk_a);
      ser_data = v[i]; ser_en_n = 0;
      if (i % 7 == 3) begin
        @(negedge clk_a);
        ser_en_n = 1; ser_data = ~v[i];
      end
    end
    @(negedge clk_a);
    ser_en_n = 1;
  endtask

  task automatic par_write(input logic [BUS_W-1:0] b);
    @(negedge clk_a);
    par_bus = b; par_wr = 1;
    @(negedge clk_a);
    par_wr = 0; par_bus = ~b;
  endtask

  function automatic logic [BUS_W-1:0] pack_par(input logic [W-1:0] v, input logic junk8);
    return {21'h15A5A, v[13:8], junk8, v[7:0]};
  endfunction

  logic [TOT-1:0] pat_a = {14'h0001, 14'h3FFC, 14'h1555, 14'h2AAA};
  logic [TOT-1:0] pat_b = {14'h2468, 14'h0ACE, 14'h3579, 14'h1BDF};

  initial begin
    // R1 / R2: reset with serial straps
    phase_tag = "R1";
    do_reset(0, 0, 1, 0);
    chk("R1", "reset offsets", {ofs_y1, ofs_x1, ofs_y2, ofs_x2}, '0);
    chk("R1", "reset rdy_a", rdy_a, 0);
    phase_tag = "R3";
    send_bits(pat_a, TOT);
    chk("R3", "Y1 after stream", ofs_y1, 14'h0001);
    chk("R3", "X2 after stream", ofs_x2, 14'h2AAA);
    chk("R2", "serial mode took stream", {ofs_x1, ofs_y2}, {14'h3FFC, 14'h1555});
    phase_tag = "R4";
    for (int i = 0; i < 10; i++) begin
      @(negedge clk_a); ser_en_n = 0; ser_data = i[0];
    end
    @(negedge clk_a); ser_en_n = 1;
    step(8);
    chk("R4", "offsets after extra bits", {ofs_y1, ofs_x1, ofs_y2, ofs_x2}, pat_a);
    chk("R5", "rdy_a high", rdy_a, 1);
    chk("R6", "rdy_b high", rdy_b, 1);

    // R11: reset part-way through a serial load
    phase_tag = "R11";
    do_reset(0, 0, 1, 0);
    send_bits(pat_a, 20);
    chk("R5", "rdy_a low mid load", rdy_a, 0);
    do_reset(0, 0, 1, 0);
    chk("R11", "offsets cleared", {ofs_y1, ofs_x1, ofs_y2, ofs_x2}, '0);
    send_bits(pat_b, TOT);
    step(8);
    chk("R11", "restart pattern", {ofs_y1, ofs_x1, ofs_y2, ofs_x2}, pat_b);

    // R7 / R9 / R10: interspersed parity, serial straps otherwise
    phase_tag = "R7";
    do_reset(0, 0, 1, 1);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk_a); ser_en_n = 0; ser_data = ~i[1];
    end
    @(negedge clk_a); ser_en_n = 1;
    chk("R7", "serial ignored with parity", {ofs_y1, ofs_x1, ofs_y2, ofs_x2}, '0);
    chk("R7", "rdy_a low", rdy_a, 0);
    phase_tag = "R9";
    par_write(pack_par(14'h2345, 1));
    par_write(pack_par(14'h00FF, 0));
    par_write(pack_par(14'h3F00, 1));
    par_write(pack_par(14'h1111, 1));
    chk("R9", "parity Y1", ofs_y1, 14'h2345);
    chk("R9", "parity X1", ofs_x1, 14'h00FF);
    chk("R9", "parity X2", ofs_x2, 14'h1111);
    phase_tag = "R10";
    par_write(pack_par(14'h0777, 1));
    step(8);
    chk("R10", "fifth write ignored", {ofs_y1, ofs_x1, ofs_y2, ofs_x2},
        {14'h2345, 14'h00FF, 14'h3F00, 14'h1111});
    chk("R6", "rdy_b after parallel", rdy_b, 1);

    // R8 / R2: parallel without parity (fs2 high)
    phase_tag = "R8";
    do_reset(1, 0, 1, 0);
    send_bits(pat_a, 8);
    chk("R2", "fs2 high is not serial", {ofs_y1, ofs_x1, ofs_y2, ofs_x2}, '0);
    par_write({22'h3FFFFF, 14'h0101});
    par_write({22'h000000, 14'h3FFC});
    par_write({22'h2AAAAA, 14'h0001});
    chk("R5", "rdy_a low after 3 words", rdy_a, 0);
    par_write({22'h155555, 14'h2100});
    step(8);
    chk("R8", "parallel words", {ofs_y1, ofs_x1, ofs_y2, ofs_x2},
        {14'h0101, 14'h3FFC, 14'h0001, 14'h2100});

    // R1: port B reset alone
    @(negedge clk_a); rst_b = 1;
    step(4);
    chk("R1", "rdy_b cleared by rst_b", rdy_b, 0);
    rst_b = 0;
    step(8);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule